// File: doc/BRIEF.md
# Property Buffer Tag Responder

This block answers query messages that a host processor leaves in shared memory. The host writes a request buffer into a word-addressed memory and hands the buffer's byte address (16-byte aligned) to the responder through a valid/ready request handshake. The responder walks the buffer. It reads a two-word header, a byte count and then a code word. It then works through a list of tags, each opened by a three-word tag header: identifier, value-buffer size in bytes, and request length in bytes. A tag identifier of zero ends the list. Recognised tags are answered in place from configuration inputs, and unrecognised tags are stepped over using their value-buffer size. At the end the code word is overwritten with a completion status, and the original address is returned on a one-cycle response strobe.

Four query tags are answered. They return the board revision, the memory base and size, a clock rate chosen by clock number, and a power state chosen by device number. The memory port is a simple synchronous single port: a read issued on one rising edge returns its data on `mem_rdata` for use in the next cycle.

The controller's states are IDLE, HDR_RD, HDR_CAP, TAG_RD, TAG_ID, TAG_VBUF, TAG_ARG, WR_VAL, WR_LEN, FIN and DONE. Its transitions are as follows:
- IDLE goes to HDR_RD when a request is accepted.
- HDR_RD goes to HDR_CAP, which goes to TAG_RD.
- TAG_RD goes to TAG_ID, or to FIN on overrun.
- TAG_ID goes to FIN on a zero identifier or on overrun, and otherwise to TAG_VBUF.
- TAG_VBUF goes to FIN on overrun, and otherwise to TAG_ARG.
- TAG_ARG goes to WR_VAL or WR_LEN for a known tag, and back to TAG_RD for an unknown one.
- WR_VAL repeats once per response word, then goes to WR_LEN.
- WR_LEN goes to TAG_RD.
- FIN goes to DONE, which goes to IDLE.

Top module: `prop_tag_responder`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until completion. Completion is a single-cycle `rsp_valid` pulse carrying the accepted address unchanged, after which `req_ready` returns to 1.
- R3: When the list ends cleanly, word 1 of the buffer (the code word) is overwritten with 0x80000000.
- R4: Tag 0x00010002 writes `cfg_board_rev` into the first value word (tag word 3). The tag's length word (tag word 2) becomes 0x80000004.
- R5: Tag 0x00010005 writes `cfg_mem_base` and then `cfg_mem_size` into value words 0 and 1. The length word becomes 0x80000008.
- R6: Tag 0x00030002 echoes the clock number from value word 0 and writes the rate into value word 1. For clock number n in 1..10 the rate is slice n-1 (bits 32(n-1)+31 down to 32(n-1)) of `cfg_clk_rates`. For any other number the rate is 0.
- R7: Tag 0x00020001 echoes the device number and writes a state word into value word 1. For device number d in 0..8, bit 0 of the state word is `cfg_dev_on[d]`. For d greater than 8 the state word is 2 (bit 1 means no such device).
- R8: A tag with any other nonzero identifier is left entirely unmodified. The next tag starts at the current tag's byte offset plus 12 plus the value-buffer size rounded up to a multiple of 4.
- R9: The response length is the smaller of the answer size and the value-buffer size, with bit 31 set. Only whole answer words that fit inside the value buffer are written.
- R10: If the walk would read beyond the declared buffer byte count before a zero identifier is found, the code word is set to 0x80000001.
- R11: A zero tag identifier ends the walk. Buffer words after it are not modified.
- R12: `mem_we` is only ever 1 together with `mem_en`, and no memory access happens while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request address offered |
| req_addr | input | 32 | Byte address of the request buffer |
| req_ready | output | 1 | Block idle and able to accept |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_addr | output | 32 | Completed buffer address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| cfg_board_rev | input | 32 | Board revision answer |
| cfg_mem_base | input | 32 | Memory base answer |
| cfg_mem_size | input | 32 | Memory size answer |
| cfg_clk_rates | input | 32*NUM_CLK | Rate per clock number, clock n in slice n-1 |
| cfg_dev_on | input | NUM_DEV | Power-on flag per device number |

## Verification
Single-tag buffers check each answer's word placement and length flag in isolation. A mixed buffer of five tags, including an out-of-range clock number and an out-of-range device number, shows that the pointer advances correctly across consecutive answered tags and that range handling works. A buffer whose unknown tag has a value size that is not a multiple of 4 tells correct rounding apart from an off-by-word skip. A value buffer too small for its answer tells length capping apart from overwriting the next tag. Buffers that are too short, and an empty list followed by a sentinel word, separate the error status from clean termination.

// File: rtl/prop_tag_pkg.sv
package prop_tag_pkg;
    typedef enum logic [3:0] {
        IDLE, HDR_RD, HDR_CAP, TAG_RD, TAG_ID, TAG_VBUF,
        TAG_ARG, WR_VAL, WR_LEN, FIN, DONE
    } walk_state_t;

    localparam logic [31:0] ID_BOARD_REV = 32'h0001_0002;
    localparam logic [31:0] ID_MEM_INFO  = 32'h0001_0005;
    localparam logic [31:0] ID_PWR_STATE = 32'h0002_0001;
    localparam logic [31:0] ID_CLK_RATE  = 32'h0003_0002;

    localparam logic [31:0] CODE_OK    = 32'h8000_0000;
    localparam logic [31:0] CODE_ERROR = 32'h8000_0001;
    localparam logic [31:0] LEN_FLAG   = 32'h8000_0000;
endpackage

// File: rtl/prop_tag_answer.sv
module prop_tag_answer
    import prop_tag_pkg::*;
#(
    parameter int NUM_CLK = 10,
    parameter int NUM_DEV = 9
) (
    input  logic [31:0]          tag_id,
    input  logic [31:0]          arg,
    input  logic [31:0]          cfg_board_rev,
    input  logic [31:0]          cfg_mem_base,
    input  logic [31:0]          cfg_mem_size,
    input  logic [NUM_CLK*32-1:0] cfg_clk_rates,
    input  logic [NUM_DEV-1:0]   cfg_dev_on,
    output logic                 known,
    output logic [1:0]           nwords,
    output logic [31:0]          word0,
    output logic [31:0]          word1
);
    logic [31:0] rate;
    logic [31:0] pstate;

    always_comb begin
        rate = '0;
        for (int i = 0; i < NUM_CLK; i++)
            if (arg == 32'(i + 1)) rate = cfg_clk_rates[i*32 +: 32];
    end

    always_comb begin
        pstate = 32'd2;
        for (int i = 0; i < NUM_DEV; i++)
            if (arg == 32'(i)) pstate = {31'd0, cfg_dev_on[i]};
    end

    always_comb begin
        known  = 1'b1;
        nwords = 2'd2;
        word0  = arg;
        word1  = '0;
        unique case (tag_id)
            ID_BOARD_REV: begin nwords = 2'd1; word0 = cfg_board_rev; end
            ID_MEM_INFO:  begin word0 = cfg_mem_base; word1 = cfg_mem_size; end
            ID_CLK_RATE:  word1 = rate;
            ID_PWR_STATE: word1 = pstate;
            default:      begin known = 1'b0; nwords = 2'd0; end
        endcase
    end
endmodule

// File: rtl/prop_tag_responder.sv
module prop_tag_responder
    import prop_tag_pkg::*;
#(
    parameter int AW      = 10,
    parameter int NUM_CLK = 10,
    parameter int NUM_DEV = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [31:0]           req_addr,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_addr,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    input  logic [31:0]           cfg_board_rev,
    input  logic [31:0]           cfg_mem_base,
    input  logic [31:0]           cfg_mem_size,
    input  logic [NUM_CLK*32-1:0] cfg_clk_rates,
    input  logic [NUM_DEV-1:0]    cfg_dev_on
);
    localparam int PW = 34;

    walk_state_t state, nxt;
    logic [31:0]   addr_q, size_q, id_q, vbuf_q, arg_q;
    logic [AW-1:0] base_w;
    logic [PW-1:0] ptr_q;
    logic          err_q, cnt_q;

    logic          known;
    logic [1:0]    nwords, nw_eff;
    logic [31:0]   word0, word1, resp_bytes, len_val;
    logic [PW-1:0] size_x, vbuf_rnd, next_ptr;
    logic          over_id, over_hdr, over_val;
    logic [AW-1:0] tag_w;

    prop_tag_answer #(.NUM_CLK(NUM_CLK), .NUM_DEV(NUM_DEV)) ans_i (
        .tag_id(id_q), .arg(arg_q),
        .cfg_board_rev(cfg_board_rev), .cfg_mem_base(cfg_mem_base),
        .cfg_mem_size(cfg_mem_size), .cfg_clk_rates(cfg_clk_rates),
        .cfg_dev_on(cfg_dev_on),
        .known(known), .nwords(nwords), .word0(word0), .word1(word1)
    );

    assign size_x     = {2'b00, size_q};
    assign vbuf_rnd   = ({2'b00, vbuf_q} + PW'(3)) & ~PW'(3);
    assign next_ptr   = ptr_q + PW'(12) + vbuf_rnd;
    assign over_id    = (ptr_q + PW'(4)) > size_x;
    assign over_hdr   = (ptr_q + PW'(12)) > size_x;
    assign over_val   = (ptr_q + PW'(12) + {2'b00, mem_rdata}) > size_x;
    assign tag_w      = base_w + ptr_q[AW+1:2];
    assign resp_bytes = {28'd0, nwords, 2'b00};
    assign len_val    = (vbuf_q < resp_bytes) ? vbuf_q : resp_bytes;
    assign nw_eff     = (vbuf_q < resp_bytes) ? vbuf_q[3:2] : nwords;

    // state register
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state <= IDLE;
        else        state <= nxt;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            IDLE:     if (req_valid) nxt = HDR_RD;
            HDR_RD:   nxt = HDR_CAP;
            HDR_CAP:  nxt = TAG_RD;
            TAG_RD:   nxt = over_id ? FIN : TAG_ID;
            TAG_ID:   nxt = (mem_rdata == 32'd0 || over_hdr) ? FIN : TAG_VBUF;
            TAG_VBUF: nxt = over_val ? FIN : TAG_ARG;
            TAG_ARG:  nxt = !known ? TAG_RD : ((nw_eff == 2'd0) ? WR_LEN : WR_VAL);
            WR_VAL:   if ({1'b0, cnt_q} == nw_eff - 2'd1) nxt = WR_LEN;
            WR_LEN:   nxt = TAG_RD;
            FIN:      nxt = DONE;
            DONE:     nxt = IDLE;
            default:  nxt = IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; base_w <= '0; size_q <= '0; ptr_q <= '0;
            id_q <= '0; vbuf_q <= '0; arg_q <= '0; err_q <= 1'b0; cnt_q <= 1'b0;
        end else begin
            unique case (state)
                IDLE: if (req_valid) begin
                    addr_q <= req_addr;
                    base_w <= req_addr[AW+1:2];
                    err_q  <= 1'b0;
                end
                HDR_CAP: begin size_q <= mem_rdata; ptr_q <= PW'(8); end
                TAG_RD:  if (over_id) err_q <= 1'b1;
                TAG_ID: begin
                    id_q <= mem_rdata;
                    if (mem_rdata != 32'd0 && over_hdr) err_q <= 1'b1;
                end
                TAG_VBUF: begin
                    vbuf_q <= mem_rdata;
                    if (over_val) err_q <= 1'b1;
                end
                TAG_ARG: begin
                    arg_q <= mem_rdata;
                    cnt_q <= 1'b0;
                    if (!known) ptr_q <= next_ptr;
                end
                WR_VAL:  cnt_q <= ~cnt_q;
                WR_LEN:  ptr_q <= next_ptr;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_addr  = addr_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = tag_w;
        mem_wdata = '0;
        unique case (state)
            IDLE:     req_ready = 1'b1;
            HDR_RD:   begin mem_en = 1'b1; mem_addr = base_w; end
            TAG_RD:   mem_en = !over_id;
            TAG_ID:   begin mem_en = 1'b1; mem_addr = tag_w + AW'(1); end
            TAG_VBUF: begin mem_en = 1'b1; mem_addr = tag_w + AW'(3); end
            WR_VAL: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr  = tag_w + AW'(3) + AW'(cnt_q);
                mem_wdata = cnt_q ? word1 : word0;
            end
            WR_LEN: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr  = tag_w + AW'(2);
                mem_wdata = LEN_FLAG | len_val;
            end
            FIN: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr  = base_w + AW'(1);
                mem_wdata = err_q ? CODE_ERROR : CODE_OK;
            end
            DONE:     rsp_valid = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/prop_tag_responder_chk.sv
module prop_tag_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        mem_en,
    input logic        mem_we
);
    logic [31:0] taken_addr;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) taken_addr <= '0;
        else if (req_valid && req_ready) taken_addr <= req_addr;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_RSP_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_addr == taken_addr); // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R2
    AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en); // R12
endmodule

bind prop_tag_responder prop_tag_responder_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/prop_tag_responder_tb.sv
`timescale 1ns/1ps
module prop_tag_responder_tb_top;
    localparam int AW = 10;
    localparam int NUM_CLK = 10;
    localparam int NUM_DEV = 9;
    localparam logic [31:0] REV  = 32'h00A0_2082;
    localparam logic [31:0] MBAS = 32'h0000_1000;
    localparam logic [31:0] MSIZ = 32'h3C00_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic req_ready, rsp_valid, mem_en, mem_we;
    logic [31:0] rsp_addr, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [NUM_CLK*32-1:0] rates;
    logic [NUM_DEV-1:0] dev_on = 9'b0_0000_0101;
    logic [31:0] mem [0:1023];
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    prop_tag_responder #(.AW(AW), .NUM_CLK(NUM_CLK), .NUM_DEV(NUM_DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cfg_board_rev(REV), .cfg_mem_base(MBAS), .cfg_mem_size(MSIZ),
        .cfg_clk_rates(rates), .cfg_dev_on(dev_on)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_req(input logic [31:0] addr);
        int n = 0;
        @(negedge clk);
        chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid && n < 3000) begin @(negedge clk); n++; end
        chk("R2 completion seen", {31'd0, rsp_valid}, 32'd1);
        chk("R2 address echoed", rsp_addr, addr);
        @(negedge clk);
        chk("R2 strobe single cycle", {31'd0, rsp_valid}, 32'd0);
        chk("R2 ready after completion", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 ready at reset", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_en at reset / R12 idle quiet", {31'd0, mem_en}, 32'd0);
    endtask

    task automatic t_board_rev();
        int b = 64;
        mem[b+0] = 28; mem[b+1] = 0;
        mem[b+2] = 32'h0001_0002; mem[b+3] = 4; mem[b+4] = 0; mem[b+5] = 32'hDEAD_BEEF;
        mem[b+6] = 0; mem[b+7] = 32'h7777_7777;
        run_req(32'h100);
        chk("R4 revision value", mem[b+5], REV);
        chk("R4 length word", mem[b+4], 32'h8000_0004);
        chk("R3 success code", mem[b+1], 32'h8000_0000);
        chk("R11 word after end untouched", mem[b+7], 32'h7777_7777);
    endtask

    task automatic t_mixed();
        int b = 128;
        mem[b+0] = 112; mem[b+1] = 0;
        mem[b+2]  = 32'h0001_0005; mem[b+3]  = 8; mem[b+4]  = 0; mem[b+5]  = 1; mem[b+6]  = 1;
        mem[b+7]  = 32'h0003_0002; mem[b+8]  = 8; mem[b+9]  = 4; mem[b+10] = 3; mem[b+11] = 9;
        mem[b+12] = 32'h0002_0001; mem[b+13] = 8; mem[b+14] = 4; mem[b+15] = 2; mem[b+16] = 9;
        mem[b+17] = 32'h0002_0001; mem[b+18] = 8; mem[b+19] = 4; mem[b+20] = 9; mem[b+21] = 9;
        mem[b+22] = 32'h0003_0002; mem[b+23] = 8; mem[b+24] = 4; mem[b+25] = 11; mem[b+26] = 9;
        mem[b+27] = 0;
        run_req(32'h200);
        chk("R5 length word", mem[b+4], 32'h8000_0008);
        chk("R5 memory base", mem[b+5], MBAS);
        chk("R5 memory size", mem[b+6], MSIZ);
        chk("R6 length word", mem[b+9], 32'h8000_0008);
        chk("R6 clock echo", mem[b+10], 32'd3);
        chk("R6 clock 3 rate", mem[b+11], 32'd3_000_000);
        chk("R7 device echo", mem[b+15], 32'd2);
        chk("R7 device 2 on", mem[b+16], 32'd1);
        chk("R7 device 9 absent", mem[b+21], 32'd2);
        chk("R6 clock 11 out of range", mem[b+26], 32'd0);
        chk("R3 success code mixed", mem[b+1], 32'h8000_0000);
    endtask

    task automatic t_unknown();
        int b = 256;
        mem[b+0] = 48; mem[b+1] = 0;
        mem[b+2] = 32'h0009_9999; mem[b+3] = 6; mem[b+4] = 0;
        mem[b+5] = 32'h1111_1111; mem[b+6] = 32'h2222_2222;
        mem[b+7] = 32'h0001_0002; mem[b+8] = 4; mem[b+9] = 0; mem[b+10] = 0;
        mem[b+11] = 0;
        run_req(32'h400);
        chk("R8 unknown id kept", mem[b+2], 32'h0009_9999);
        chk("R8 unknown size kept", mem[b+3], 32'd6);
        chk("R8 unknown length kept", mem[b+4], 32'd0);
        chk("R8 unknown value kept", mem[b+5], 32'h1111_1111);
        chk("R8 unknown pad kept", mem[b+6], 32'h2222_2222);
        chk("R8 rounded skip reaches next tag", mem[b+10], REV);
        chk("R8 next tag length", mem[b+9], 32'h8000_0004);
    endtask

    task automatic t_capped();
        int b = 384;
        mem[b+0] = 44; mem[b+1] = 0;
        mem[b+2] = 32'h0001_0005; mem[b+3] = 4; mem[b+4] = 0; mem[b+5] = 32'hFFFF_FFFF;
        mem[b+6] = 32'h0001_0002; mem[b+7] = 4; mem[b+8] = 0; mem[b+9] = 0;
        mem[b+10] = 0;
        run_req(32'h600);
        chk("R9 capped length", mem[b+4], 32'h8000_0004);
        chk("R9 first word written", mem[b+5], MBAS);
        chk("R9 next tag id not overwritten", mem[b+6], 32'h0001_0002);
        chk("R9 following tag answered", mem[b+9], REV);
    endtask

    task automatic t_overrun();
        int b = 512;
        mem[b+0] = 24; mem[b+1] = 0;
        mem[b+2] = 32'h0001_0002; mem[b+3] = 4; mem[b+4] = 0; mem[b+5] = 0;
        mem[b+6] = 32'h1234_5678;
        run_req(32'h800);
        chk("R10 missing terminator", mem[b+1], 32'h8000_0001);
        b = 576;
        mem[b+0] = 16; mem[b+1] = 0;
        mem[b+2] = 32'h0001_0002; mem[b+3] = 4; mem[b+4] = 0; mem[b+5] = 32'h5555_5555;
        run_req(32'h900);
        chk("R10 tag header overruns", mem[b+1], 32'h8000_0001);
        chk("R10 overrun tag not answered", mem[b+5], 32'h5555_5555);
    endtask

    task automatic t_empty();
        int b = 640;
        mem[b+0] = 12; mem[b+1] = 0; mem[b+2] = 0; mem[b+3] = 32'hCAFE_F00D;
        run_req(32'hA00);
        chk("R11 empty list success", mem[b+1], 32'h8000_0000);
        chk("R11 size word untouched", mem[b+0], 32'd12);
        chk("R11 sentinel untouched", mem[b+3], 32'hCAFE_F00D);
    endtask

    initial begin
        for (int i = 0; i < NUM_CLK; i++) rates[i*32 +: 32] = 32'((i + 1) * 1000000);
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_board_rev();
        t_mixed();
        t_unknown();
        t_capped();
        t_overrun();
        t_empty();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule